// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the command pins of a four-bank synchronous DRAM, as a memory controller drives them. On every clock it decodes the pins into one command and tracks the state of each bank: idle, opening, open, recovering from a write, waiting for an automatic close, or closing. It reports any command that the addressed bank's state or the elapsed time does not allow. Every minimum delay is a parameter counted in clock cycles.

The monitor sits beside the controller, or in a verification environment. Its outputs are registered. The cycle after the clock edge that sampled a command, it presents the decoded command, the bank states and, for an illegal command, a one-cycle error flag with a code that names the rule broken. An illegal command changes no bank state and starts no timer, so one mistake does not produce a chain of follow-on errors.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command is decoded from {cs_n, ras_n, cas_n, we_n} only when CKE was high at the previous edge. The `cmd_o` codes are: 0 deselect (cs_n high), 1 no-op (0111), 2 open row (0011), 3 read (0101, A10 low), 4 read with auto-close (0101, A10 high), 5 write (0100, A10 low), 6 write with auto-close (0100, A10 high), 7 close one bank (0010, A10 low), 8 close all banks (0010, A10 high), 9 refresh (0001 with CKE high), 10 self-refresh entry (0001 with CKE low), 11 mode register set (0000), 12 burst stop (0110), 13 suspended (CKE low at the previous edge). Deselect, no-op, burst stop and suspended are never errors.
- R2: Outputs are registered and appear one cycle after the sampling edge. Reset sets `cmd_o`=0, no error, and every bank to idle. The bank state codes are 0 idle, 1 opening, 2 open, 3 write recovery, 4 auto-close pending and 5 closing, with bank n in bits [3n+2:3n].
- R3: A read or write to a bank that is idle or closing gives code 1. A read or write before T_RCD cycles have passed since the bank was opened gives code 2.
- R4: Opening a bank that is opening, open or in write recovery gives code 3. Opening a bank fewer than T_RP cycles after it was closed gives code 4. A legal open puts the bank in the opening state.
- R5: Closing a bank fewer than T_RAS cycles after it was opened gives code 5. Opening any bank fewer than T_RRD cycles after the last legal open gives code 6.
- R6: A write without auto-close puts the bank in write recovery for BURST_LEN-1+T_DPL cycles. Closing the bank during that window gives code 7, while reads and writes to it stay legal.
- R7: A read or write with A10 high puts the bank in auto-close pending. For a read this lasts BURST_LEN cycles; for a write it lasts BURST_LEN-1+T_DPL cycles. The bank is then closing for T_RP cycles. Any open, read, write or close aimed at a pending bank gives code 10.
- R8: Close-all checks every bank and closes every open bank. If any bank forbids it, nothing changes and the code of the lowest-numbered offending bank is reported. Close-one touches only the addressed bank. Closing an idle or closing bank is legal and changes nothing.
- R9: Refresh, self-refresh entry and mode register set need every bank idle (code 8). After a legal refresh the device is busy for T_RC cycles; after a mode register set it is busy for T_MRD cycles. During that time any command other than those listed in R1 as never errors gives code 9.
- R10: An illegal command raises `err_o` for exactly the cycle of its report, with a nonzero `err_code_o`, and leaves every bank state unchanged.
- R11: While CKE was low at the previous edge, commands are ignored. When CKE rises after a self-refresh entry, the device is busy for T_RC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin as observed |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | $clog2(NUM_BANKS) | Bank address |
| ap_i | input | 1 | Address bit 10: auto-close / all-banks select |
| cmd_o | output | 4 | Decoded command code (R1) |
| err_o | output | 1 | Illegal command flag |
| err_code_o | output | 4 | Rule broken (0 when legal) |
| bank_state_o | output | 3*NUM_BANKS | Per-bank state codes (R2) |

## Verification
Some properties are checked on every cycle. The never-error commands, including suspended cycles, must never raise an error. A legal open must show the opening state. A legal auto-close command must show the pending state. A legal close-all must leave each bank idle or closing. After a refresh, an open must be rejected. A legal read or write must never follow an idle or closing bank state. Only the bench's scenarios can show the exact cycles at which each delay expires, the lowest-bank rule for close-all, the self-refresh exit window, and that a rejected command leaves the bank states as they were.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 7,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 10,
  parameter int T_DPL     = 2,
  parameter int T_MRD     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke_i,
  input  logic                         cs_n_i,
  input  logic                         ras_n_i,
  input  logic                         cas_n_i,
  input  logic                         we_n_i,
  input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
  input  logic                         ap_i,
  output logic [3:0]                   cmd_o,
  output logic                         err_o,
  output logic [3:0]                   err_code_o,
  output logic [3*NUM_BANKS-1:0]       bank_state_o
);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int BAW  = $clog2(NUM_BANKS);
  localparam int MAXT = imax(imax(imax(T_RC, T_RAS), imax(T_RCD, T_RP)),
                             imax(imax(T_RRD, T_MRD), BURST_LEN + T_DPL));
  localparam int CW   = $clog2(MAXT + 1);

  localparam logic [3:0] C_DES = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
                         C_RDA = 4'd4, C_WR = 4'd5, C_WRA = 4'd6, C_PRE = 4'd7,
                         C_PREA = 4'd8, C_REF = 4'd9, C_SREF = 4'd10, C_MRS = 4'd11,
                         C_BST = 4'd12, C_SUSP = 4'd13;

  localparam logic [3:0] E_NONE = 4'd0, E_NOPEN = 4'd1, E_TRCD = 4'd2, E_OPEN = 4'd3,
                         E_TRP = 4'd4, E_TRAS = 4'd5, E_TRRD = 4'd6, E_TDPL = 4'd7,
                         E_NIDLE = 4'd8, E_BUSY = 4'd9, E_APND = 4'd10;

  localparam logic [2:0] S_IDLE = 3'd0, S_ACTG = 3'd1, S_ACT = 3'd2,
                         S_WREC = 3'd3, S_APND = 3'd4, S_PRE = 3'd5;

  localparam logic [CW-1:0] L_RCD  = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RRD  = CW'(T_RRD - 1);
  localparam logic [CW-1:0] L_RC   = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_MRD  = CW'(T_MRD - 1);
  localparam logic [CW-1:0] L_WREC = CW'(BURST_LEN + T_DPL - 2);
  localparam logic [CW-1:0] L_RDAP = CW'(BURST_LEN - 1);

  function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic          cke_q, in_sref;
  logic [CW-1:0] busy_q, rrd_q;
  logic [2:0]    st_q   [NUM_BANKS];
  logic [CW-1:0] cnt_q  [NUM_BANKS];
  logic [CW-1:0] ras_q  [NUM_BANKS];
  logic [2:0]    eff    [NUM_BANKS];
  logic [3:0]    pre_err[NUM_BANKS];
  logic          all_idle;
  logic [3:0]    cmd, code;
  logic [2:0]    es;
  logic          ok;

  always_comb begin
    if (!cke_q)      cmd = C_SUSP;
    else if (cs_n_i) cmd = C_DES;
    else begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  cmd = C_NOP;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = ap_i ? C_RDA : C_RD;
        3'b100:  cmd = ap_i ? C_WRA : C_WR;
        3'b010:  cmd = ap_i ? C_PREA : C_PRE;
        3'b001:  cmd = cke_i ? C_REF : C_SREF;
        3'b000:  cmd = C_MRS;
        default: cmd = C_BST;
      endcase
    end
  end

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      eff[b] = st_q[b];
      if (cnt_q[b] == '0) begin
        case (st_q[b])
          S_ACTG, S_WREC: eff[b] = S_ACT;
          S_APND:         eff[b] = S_PRE;
          S_PRE:          eff[b] = S_IDLE;
          default:        eff[b] = st_q[b];
        endcase
      end
      case (eff[b])
        S_ACTG, S_ACT: pre_err[b] = (ras_q[b] != '0) ? E_TRAS : E_NONE;
        S_WREC:        pre_err[b] = E_TDPL;
        S_APND:        pre_err[b] = E_APND;
        default:       pre_err[b] = E_NONE;
      endcase
      if (eff[b] != S_IDLE) all_idle = 1'b0;
    end
  end

  assign es = eff[ba_i];

  always_comb begin
    code = E_NONE;
    if (busy_q != '0 && !(cmd inside {C_DES, C_NOP, C_BST, C_SUSP})) code = E_BUSY;
    else begin
      case (cmd)
        C_ACT: begin
          case (es)
            S_IDLE:  code = (rrd_q != '0) ? E_TRRD : E_NONE;
            S_PRE:   code = E_TRP;
            S_APND:  code = E_APND;
            default: code = E_OPEN;
          endcase
        end
        C_RD, C_RDA, C_WR, C_WRA: begin
          case (es)
            S_IDLE, S_PRE: code = E_NOPEN;
            S_ACTG:        code = E_TRCD;
            S_APND:        code = E_APND;
            default:       code = E_NONE;
          endcase
        end
        C_PRE: code = pre_err[ba_i];
        C_PREA: begin
          for (int b = NUM_BANKS - 1; b >= 0; b--)
            if (pre_err[b] != E_NONE) code = pre_err[b];
        end
        C_REF, C_SREF, C_MRS: code = all_idle ? E_NONE : E_NIDLE;
        default: code = E_NONE;
      endcase
    end
  end

  assign ok = (code == E_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        st_q[b]  <= S_IDLE;
        cnt_q[b] <= '0;
        ras_q[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        st_q[b]  <= eff[b];
        cnt_q[b] <= dn(cnt_q[b]);
        ras_q[b] <= dn(ras_q[b]);
        if (st_q[b] == S_APND && cnt_q[b] == '0) cnt_q[b] <= L_RP;
        if (ok && (ba_i == b[BAW-1:0] || cmd == C_PREA)) begin
          case (cmd)
            C_ACT: if (cmd == C_ACT && ba_i == b[BAW-1:0]) begin
              st_q[b]  <= S_ACTG;
              cnt_q[b] <= L_RCD;
              ras_q[b] <= L_RAS;
            end
            C_WR: begin
              st_q[b]  <= S_WREC;
              cnt_q[b] <= L_WREC;
            end
            C_WRA: begin
              st_q[b]  <= S_APND;
              cnt_q[b] <= L_WREC;
            end
            C_RDA: begin
              st_q[b]  <= S_APND;
              cnt_q[b] <= L_RDAP;
            end
            C_PRE, C_PREA: if (eff[b] == S_ACTG || eff[b] == S_ACT) begin
              st_q[b]  <= S_PRE;
              cnt_q[b] <= L_RP;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q      <= 1'b1;
      in_sref    <= 1'b0;
      busy_q     <= '0;
      rrd_q      <= '0;
      cmd_o      <= C_DES;
      err_o      <= 1'b0;
      err_code_o <= E_NONE;
    end else begin
      cke_q      <= cke_i;
      cmd_o      <= cmd;
      err_code_o <= code;
      err_o      <= !ok;
      busy_q     <= dn(busy_q);
      rrd_q      <= dn(rrd_q);
      if (ok) begin
        case (cmd)
          C_REF:   busy_q  <= L_RC;
          C_MRS:   busy_q  <= L_MRD;
          C_SREF:  in_sref <= 1'b1;
          C_ACT:   rrd_q   <= L_RRD;
          default: ;
        endcase
      end
      if (in_sref && !cke_q && cke_i) begin
        in_sref <= 1'b0;
        busy_q  <= L_RC;
      end
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_state
    assign bank_state_o[3*g +: 3] = st_q[g];
  end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 10
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [$clog2(NUM_BANKS)-1:0] ba_i,
  input logic [3:0]                   cmd_o,
  input logic                         err_o,
  input logic [3*NUM_BANKS-1:0]       bank_state_o
);
  localparam int BAW = $clog2(NUM_BANKS);

  assert_quiet_cmds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o inside {4'd0, 4'd1, 4'd12}) |-> !err_o);

  assert_suspend_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd13) |-> !err_o);

  if (T_RC > 1) begin : g_ref
    assert_ref_blocks_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 4'd9 && !err_o) |=> (cmd_o != 4'd2 || err_o));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state_o[3*b +: 3] <= 3'd5);

    if (T_RCD > 1) begin : g_open
      assert_open_sets_opening_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd2 && !err_o && $past(ba_i) == BAW'(b)) |-> bank_state_o[3*b +: 3] == 3'd1);
    end

    assert_access_needs_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o inside {4'd3, 4'd4, 4'd5, 4'd6} && !err_o && $past(ba_i) == BAW'(b))
        |-> !($past(bank_state_o[3*b +: 3]) inside {3'd0, 3'd5}));

    assert_autoclose_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o inside {4'd4, 4'd6} && !err_o && $past(ba_i) == BAW'(b))
        |-> bank_state_o[3*b +: 3] == 3'd4);

    assert_close_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 4'd8 && !err_o) |-> (bank_state_o[3*b +: 3] inside {3'd0, 3'd5}));
  end
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RC(T_RC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ba_i(ba_i), .cmd_o(cmd_o),
  .err_o(err_o), .bank_state_o(bank_state_o)
);

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0]  ba = 2'd0;
  logic [3:0]  cmd_o, err_code_o;
  logic        err_o;
  logic [11:0] bank_state_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .ap_i(a10),
    .cmd_o(cmd_o), .err_o(err_o), .err_code_o(err_code_o), .bank_state_o(bank_state_o)
  );

  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000,
                         P_BST = 4'b0110, P_DES = 4'b1111;

  // {cke, pattern, bank, a10, expected command, expected code}
  localparam int NV = 42;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, P_MRS, 2'd0, 1'b0, 4'd11, 4'd0},
    {1'b1, P_ACT, 2'd0, 1'b0, 4'd2,  4'd9},
    {1'b1, P_ACT, 2'd0, 1'b0, 4'd2,  4'd0},
    {1'b1, P_ACT, 2'd1, 1'b0, 4'd2,  4'd6},
    {1'b1, P_ACT, 2'd1, 1'b0, 4'd2,  4'd0},
    {1'b1, P_RD,  2'd0, 1'b0, 4'd3,  4'd0},
    {1'b1, P_WR,  2'd1, 1'b0, 4'd5,  4'd2},
    {1'b1, P_ACT, 2'd0, 1'b0, 4'd2,  4'd3},
    {1'b1, P_PRE, 2'd0, 1'b0, 4'd7,  4'd5},
    {1'b1, P_PRE, 2'd0, 1'b0, 4'd7,  4'd0},
    {1'b1, P_ACT, 2'd0, 1'b0, 4'd2,  4'd4},
    {1'b1, P_RD,  2'd0, 1'b0, 4'd3,  4'd1},
    {1'b1, P_WR,  2'd1, 1'b0, 4'd5,  4'd0},
    {1'b1, P_PRE, 2'd1, 1'b0, 4'd7,  4'd7},
    {1'b1, P_REF, 2'd0, 1'b0, 4'd9,  4'd8},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_PRE, 2'd1, 1'b0, 4'd7,  4'd7},
    {1'b1, P_PRE, 2'd1, 1'b0, 4'd7,  4'd0},
    {1'b1, P_DES, 2'd0, 1'b0, 4'd0,  4'd0},
    {1'b1, P_BST, 2'd0, 1'b0, 4'd12, 4'd0},
    {1'b1, P_REF, 2'd0, 1'b0, 4'd9,  4'd0},
    {1'b1, P_ACT, 2'd2, 1'b0, 4'd2,  4'd9},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_ACT, 2'd2, 1'b0, 4'd2,  4'd0},
    {1'b1, P_ACT, 2'd3, 1'b0, 4'd2,  4'd6},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_WR,  2'd2, 1'b1, 4'd6,  4'd0},
    {1'b1, P_RD,  2'd2, 1'b0, 4'd3,  4'd10},
    {1'b1, P_ACT, 2'd3, 1'b0, 4'd2,  4'd0},
    {1'b1, P_PRE, 2'd0, 1'b1, 4'd8,  4'd10},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_NOP, 2'd0, 1'b0, 4'd1,  4'd0},
    {1'b1, P_ACT, 2'd2, 1'b0, 4'd2,  4'd4},
    {1'b1, P_ACT, 2'd2, 1'b0, 4'd2,  4'd0}
  };

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7:       return "R6";
      4'd8, 4'd9: return "R9";
      4'd10:      return "R7";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic issue(input logic k, input logic [3:0] p, input logic [1:0] b, input logic a);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; a10 = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(1'b1, P_NOP, 2'd0, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", "reset cmd", cmd_o, 4'd0);
    check("R2", "reset err", err_o, 1'b0);
    check("R2", "reset states", bank_state_o, 12'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][15], VEC[i][14:11], VEC[i][10:9], VEC[i][8]);
      check("R1", $sformatf("vec %0d cmd", i), cmd_o, VEC[i][7:4]);
      check(req_of(VEC[i][3:0]), $sformatf("vec %0d code", i), err_code_o, VEC[i][3:0]);
      check("R10", $sformatf("vec %0d flag", i), err_o, VEC[i][3:0] != 4'd0);
    end

    // R10: the rejected close-all left bank 3 open; R4: bank 2 opening again
    check("R10", "states after table", bank_state_o, {3'd2, 3'd1, 3'd0, 3'd0});

    nops(7);
    issue(1'b1, P_PRE, 2'd0, 1'b1);
    check("R8", "close-all legal", err_code_o, 4'd0);
    check("R8", "close-all states", bank_state_o, {3'd5, 3'd5, 3'd0, 3'd0});
    nops(2);
    check("R4", "still closing before tRP", bank_state_o, {3'd5, 3'd5, 3'd0, 3'd0});
    nops(1);
    check("R4", "idle after tRP", bank_state_o, 12'h000);

    issue(1'b0, P_REF, 2'd0, 1'b0);
    check("R11", "self-refresh entry cmd", cmd_o, 4'd10);
    check("R9", "self-refresh entry legal", err_code_o, 4'd0);
    issue(1'b0, P_ACT, 2'd0, 1'b0);
    check("R11", "suspended cmd", cmd_o, 4'd13);
    check("R11", "suspended no error", err_o, 1'b0);
    check("R11", "suspended open ignored", bank_state_o, 12'h000);
    issue(1'b1, P_NOP, 2'd0, 1'b0);
    check("R11", "exit cycle suspended", cmd_o, 4'd13);
    issue(1'b1, P_ACT, 2'd1, 1'b0);
    check("R11", "busy after exit", err_code_o, 4'd9);
    check("R10", "busy open ignored", bank_state_o, 12'h000);

    nops(8);
    issue(1'b1, P_ACT, 2'd1, 1'b0);
    check("R11", "open after exit window", err_code_o, 4'd0);
    nops(2);
    issue(1'b1, P_RD, 2'd1, 1'b1);
    check("R7", "read auto-close cmd", cmd_o, 4'd4);
    check("R7", "read auto-close pending", bank_state_o, {3'd0, 3'd0, 3'd4, 3'd0});
    issue(1'b1, P_WR, 2'd1, 1'b0);
    check("R7", "write to pending bank", err_code_o, 4'd10);
    check("R10", "pending kept", bank_state_o, {3'd0, 3'd0, 3'd4, 3'd0});
    issue(1'b1, P_MRS, 2'd0, 1'b0);
    check("R9", "mode set with busy bank", err_code_o, 4'd8);
    nops(1);
    check("R7", "pending until burst end", bank_state_o, {3'd0, 3'd0, 3'd4, 3'd0});
    nops(1);
    check("R7", "closing after burst", bank_state_o, {3'd0, 3'd0, 3'd5, 3'd0});
    nops(3);
    check("R7", "idle after auto-close", bank_state_o, 12'h000);

    finish_run();
  end
endmodule